// File: doc/BRIEF.md
# Splittable Performance Counter Array

This block is a register-mapped event counter bank for performance monitoring. It holds a set of physical counters, four by default. Each one counts a single wide event stream, or, when software flips its split bit in the control word, it acts as two narrow counters that count separate event streams. That gives twice as many logical counter numbers as physical counters. A status word collects wrap events from every logical counter and drives a level interrupt through a software mask.

Software never writes a live counter directly. A counter write lands in a holding latch and raises a pending flag. The latch is copied into the live counter when the control word is next written with its run bit set, whether or not the monitor was already running. While a flag is pending, a read of that counter shows the latch, so software always sees the newest value it wrote. Every register is a 32-bit word carried in the upper half of a 64-bit slot. Reads return data on the cycle after the request.

Top module: `perfctr_array`

## Requirements
- R1: After reset every counter, latch, pending flag, the control word, the interrupt mask and the status bits are zero, all slot reads return zero, and `irq` is low.
- R2: With control bit p (split) clear and control bit 31 (run) set, physical counter p adds one on each clock where `event_in[p]` is high. `event_in[p+NUM_PHYS]` is ignored, and both slot p and slot p+NUM_PHYS read the full 32-bit value.
- R3: With split bit p set, slot p is the upper 16-bit half and slot p+NUM_PHYS is the lower half. The upper half counts `event_in[p]` and the lower half counts `event_in[p+NUM_PHYS]`. No carry passes from the lower half to the upper half.
- R4: A write to counter slots 0..2*NUM_PHYS-1 loads only the holding latch and sets that counter's pending flag; the live count carries on. While the flag is set, reads of that counter return the latched value.
- R5: A write to control slot 2*NUM_PHYS with bit 31 set copies every pending latch into its live counter in that cycle and clears all pending flags. This holds even when the run bit was already set.
- R6: In split mode a write to one half keeps the other half at its newest value (latched if pending, otherwise live) in the latch.
- R7: While the run bit is clear, no counter changes and all values are kept.
- R8: A wrap from all ones to zero of logical counter i (a full counter uses bit p) sets status bit i. A read of status slot 2*NUM_PHYS+1 returns the bits and clears them. A wrap in the same cycle as the read stays set.
- R9: A write to the status slot sets the interrupt mask from its bits. `irq` is high exactly while some status bit and its mask bit are both set, and a zero mask keeps `irq` low.
- R10: Register data sits in bits 63:32 of a slot. Bits 31:0 read as zero and are ignored on write. Read data appears on `rd_data` one cycle after the request. Unused slots read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (4) | Slot number: counters, then control, then status |
| req_wdata | input | 2*REG_W (64) | Write data, word in the upper half |
| rd_data | output | 2*REG_W (64) | Read data, valid the cycle after a read |
| event_in | input | 2*NUM_PHYS (8) | Event inputs, one per logical counter |
| irq | output | 1 | Level interrupt, masked status |

## Verification
On every cycle the assertions check four things: a stopped monitor holds its counts, a commit leaves no flag pending, a lower-half count never disturbs a split counter's upper half, and a status read leaves no bit behind. Each cycle they also check that an enabled wrap raises the interrupt. Only the bench scenarios can show the other behaviour. That covers how split and full reads map onto slots and how a half write merges with the other half. It also covers reads that return the pending latch, commits while the monitor is already running, and the exact cycle and index of each wrap. A behavioural model compares every read and the interrupt line across random traffic in both widths.

// File: rtl/perfctr_pkg.sv
package perfctr_pkg;
   typedef enum logic [1:0] {
      SLOT_NONE = 2'd0,
      SLOT_CTR  = 2'd1,
      SLOT_CTRL = 2'd2,
      SLOT_STAT = 2'd3
   } slot_kind_e;
endpackage

// File: rtl/perfctr_cell.sv
module perfctr_cell #(
   parameter int CTR_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             count_en,
   input  logic             split,
   input  logic             ev_hi,
   input  logic             ev_lo,
   input  logic             wr_en,
   input  logic             wr_lower,
   input  logic [CTR_W-1:0] wr_val,
   input  logic             commit,
   output logic [CTR_W-1:0] view,
   output logic             ovf_hi,
   output logic             ovf_lo
);
   localparam int HALF_W = CTR_W / 2;

   logic [CTR_W-1:0]  live_q, live_d, latch_q, latch_d, cur;
   logic              pend_q;
   logic              take;
   logic [HALF_W-1:0] hi, lo;

   assign cur  = pend_q ? latch_q : live_q;
   assign view = cur;
   assign take = commit && pend_q;
   assign hi   = live_q[CTR_W-1:HALF_W];
   assign lo   = live_q[HALF_W-1:0];

   always_comb begin
      live_d = live_q;
      ovf_hi = 1'b0;
      ovf_lo = 1'b0;
      if (take) begin
         live_d = latch_q;
      end else if (count_en) begin
         if (split) begin
            if (ev_hi) begin
               live_d[CTR_W-1:HALF_W] = hi + 1'b1;
               ovf_hi = &hi;
            end
            if (ev_lo) begin
               live_d[HALF_W-1:0] = lo + 1'b1;
               ovf_lo = &lo;
            end
         end else if (ev_hi) begin
            live_d = live_q + 1'b1;
            ovf_hi = &live_q;
         end
      end
   end

   always_comb begin
      latch_d = latch_q;
      if (wr_en) begin
         if (!split)
            latch_d = wr_val;
         else if (wr_lower)
            latch_d = {cur[CTR_W-1:HALF_W], wr_val[HALF_W-1:0]};
         else
            latch_d = {wr_val[HALF_W-1:0], cur[HALF_W-1:0]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q  <= '0;
         latch_q <= '0;
         pend_q  <= 1'b0;
      end else begin
         live_q  <= live_d;
         latch_q <= latch_d;
         if (wr_en)
            pend_q <= 1'b1;
         else if (commit)
            pend_q <= 1'b0;
      end
   end

   // R7
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!count_en && !(commit && pend_q)) |=> $stable(live_q));

   // R4
   latch_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !count_en) |=> $stable(live_q));

   // R5
   commit_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !pend_q);

   // R3
   no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count_en && split && !ev_hi && !(commit && pend_q))
      |=> $stable(live_q[CTR_W-1:HALF_W]));
endmodule

// File: rtl/perfctr_status.sv
module perfctr_status #(
   parameter int NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] ovf,
   input  logic               rd_clr,
   input  logic               mask_wr,
   input  logic [NUM_SRC-1:0] mask_val,
   output logic [NUM_SRC-1:0] status,
   output logic               irq
);
   logic [NUM_SRC-1:0] stat_q, mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         mask_q <= '0;
      end else begin
         stat_q <= (rd_clr ? '0 : stat_q) | ovf;
         if (mask_wr)
            mask_q <= mask_val;
      end
   end

   assign status = stat_q;
   assign irq    = |(stat_q & mask_q);

   // R8
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && ovf == '0) |=> stat_q == '0);

   // R9
   irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(ovf & mask_q)) && !mask_wr) |=> irq);
endmodule

// File: rtl/perfctr_array.sv
module perfctr_array
   import perfctr_pkg::*;
#(
   parameter int NUM_PHYS = 4,
   parameter int CTR_W    = 32,
   parameter int REG_W    = 32,
   localparam int NUM_LOG = 2 * NUM_PHYS,
   localparam int ADDR_W  = $clog2(NUM_LOG + 2)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [2*REG_W-1:0]   req_wdata,
   output logic [2*REG_W-1:0]   rd_data,
   input  logic [NUM_LOG-1:0]   event_in,
   output logic                 irq
);
   localparam int HALF_W    = CTR_W / 2;
   localparam int PHYS_W    = $clog2(NUM_PHYS);
   localparam int LOG_W     = PHYS_W + 1;
   localparam int CTRL_SLOT = NUM_LOG;
   localparam int STAT_SLOT = NUM_LOG + 1;
   localparam int EN_BIT    = REG_W - 1;

   if (NUM_PHYS < 2 || (1 << PHYS_W) != NUM_PHYS)
      $error("NUM_PHYS must be a power of two, at least 2");
   if (CTR_W % 2 != 0 || CTR_W > REG_W || CTR_W < 2)
      $error("CTR_W must be even and fit in REG_W");
   if (NUM_LOG > REG_W || NUM_PHYS > EN_BIT)
      $error("REG_W too narrow for control and status fields");

   slot_kind_e         kind;
   logic [REG_W-1:0]   wdata_hi, ctrl_q, rd_word, sel_word;
   logic [LOG_W-1:0]   idx;
   logic [PHYS_W-1:0]  phys;
   logic               lower, is_wr, is_rd, ctr_wr, ctrl_wr, stat_wr, stat_rd, commit;
   logic [CTR_W-1:0]   view [NUM_PHYS];
   logic [NUM_LOG-1:0] ovf, status;
   logic               unused_lo;

   assign wdata_hi  = req_wdata[2*REG_W-1:REG_W];
   assign unused_lo = ^req_wdata[REG_W-1:0];
   assign idx       = req_addr[LOG_W-1:0];
   assign phys      = idx[PHYS_W-1:0];
   assign lower     = idx[LOG_W-1];

   always_comb begin
      kind = SLOT_NONE;
      if (req_addr < ADDR_W'(NUM_LOG))
         kind = SLOT_CTR;
      else if (req_addr == ADDR_W'(CTRL_SLOT))
         kind = SLOT_CTRL;
      else if (req_addr == ADDR_W'(STAT_SLOT))
         kind = SLOT_STAT;
   end

   assign is_wr   = req_valid && req_write;
   assign is_rd   = req_valid && !req_write;
   assign ctr_wr  = is_wr && (kind == SLOT_CTR);
   assign ctrl_wr = is_wr && (kind == SLOT_CTRL);
   assign stat_wr = is_wr && (kind == SLOT_STAT);
   assign stat_rd = is_rd && (kind == SLOT_STAT);
   assign commit  = ctrl_wr && wdata_hi[EN_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (ctrl_wr)
         ctrl_q <= wdata_hi;
   end

   for (genvar g = 0; g < NUM_PHYS; g++) begin : g_cell
      perfctr_cell #(.CTR_W(CTR_W)) u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .count_en (ctrl_q[EN_BIT]),
         .split    (ctrl_q[g]),
         .ev_hi    (event_in[g]),
         .ev_lo    (event_in[g+NUM_PHYS]),
         .wr_en    (ctr_wr && (phys == PHYS_W'(g))),
         .wr_lower (lower),
         .wr_val   (wdata_hi[CTR_W-1:0]),
         .commit   (commit),
         .view     (view[g]),
         .ovf_hi   (ovf[g]),
         .ovf_lo   (ovf[g+NUM_PHYS])
      );
   end

   perfctr_status #(.NUM_SRC(NUM_LOG)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .ovf      (ovf),
      .rd_clr   (stat_rd),
      .mask_wr  (stat_wr),
      .mask_val (wdata_hi[NUM_LOG-1:0]),
      .status   (status),
      .irq      (irq)
   );

   always_comb begin
      if (!ctrl_q[phys])
         sel_word = REG_W'(view[phys]);
      else if (lower)
         sel_word = REG_W'(view[phys][HALF_W-1:0]);
      else
         sel_word = REG_W'(view[phys][CTR_W-1:HALF_W]);
   end

   always_comb begin
      case (kind)
         SLOT_CTR:  rd_word = sel_word;
         SLOT_CTRL: rd_word = ctrl_q;
         SLOT_STAT: rd_word = REG_W'(status);
         default:   rd_word = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else if (is_rd)
         rd_data <= {rd_word, {REG_W{1'b0}}};
   end
endmodule

// File: tb/perfctr_array_test.sv
`timescale 1ns/1ps
module perfctr_array_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [3:0]  req_addr = '0;
   logic [63:0] req_wdata = '0;
   logic [63:0] rd_data;
   logic [7:0]  event_in = '0;
   logic        irq;

   int checks = 0, failures = 0;
   bit done = 0;

   always #10 clk = ~clk;

   perfctr_array uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
      .event_in(event_in), .irq(irq)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   logic [31:0] m_live [4];
   logic [31:0] m_latch [4];
   logic [3:0]  m_pend;
   logic [31:0] m_ctrl;
   logic [7:0]  m_mask, m_stat;
   logic [63:0] m_rd;
   bit          m_rdv;
   string       m_tag;

   always @(posedge clk) begin : model
      logic [31:0] nlive [4];
      logic [31:0] cur, w;
      logic [7:0]  ovf;
      int unsigned hi, lo, a, p;
      bit commit;
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin m_live[i] = 0; m_latch[i] = 0; end
         m_pend = 0; m_ctrl = 0; m_mask = 0; m_stat = 0; m_rdv = 0;
      end else begin
         a = req_addr;
         w = req_wdata[63:32];
         ovf = 0;
         commit = req_valid && req_write && a == 8 && w[31];
         for (int i = 0; i < 4; i++) begin
            nlive[i] = m_live[i];
            if (commit && m_pend[i]) nlive[i] = m_latch[i];
            else if (m_ctrl[31]) begin
               if (m_ctrl[i]) begin
                  hi = m_live[i][31:16];
                  lo = m_live[i][15:0];
                  if (event_in[i]) begin
                     if (hi == 65535) ovf[i] = 1;
                     hi = (hi + 1) % 65536;
                  end
                  if (event_in[i+4]) begin
                     if (lo == 65535) ovf[i+4] = 1;
                     lo = (lo + 1) % 65536;
                  end
                  nlive[i] = (hi << 16) | lo;
               end else if (event_in[i]) begin
                  if (m_live[i] == 32'hFFFF_FFFF) ovf[i] = 1;
                  nlive[i] = m_live[i] + 1;
               end
            end
         end
         m_rdv = req_valid && !req_write;
         if (m_rdv) begin
            m_rd = 0;
            if (a < 8) begin
               p = a % 4;
               cur = m_pend[p] ? m_latch[p] : m_live[p];
               if (m_ctrl[p]) cur = (a < 4) ? (cur >> 16) : (cur & 32'hFFFF);
               m_rd = {cur, 32'h0};
               m_tag = "R4 counter read";
            end else if (a == 8) begin
               m_rd = {m_ctrl, 32'h0}; m_tag = "R5 control read";
            end else if (a == 9) begin
               m_rd = {24'h0, m_stat, 32'h0}; m_tag = "R8 status read";
            end else m_tag = "R10 empty slot read";
         end
         if (req_valid && req_write) begin
            if (a < 8) begin
               p = a % 4;
               cur = m_pend[p] ? m_latch[p] : m_live[p];
               if (!m_ctrl[p]) m_latch[p] = w;
               else if (a < 4) m_latch[p] = {w[15:0], cur[15:0]};
               else m_latch[p] = {cur[31:16], w[15:0]};
               m_pend[p] = 1;
            end else if (a == 8) begin
               m_ctrl = w;
               if (commit) m_pend = 0;
            end else if (a == 9) m_mask = w[7:0];
         end
         m_stat = ((req_valid && !req_write && a == 9) ? 8'h0 : m_stat) | ovf;
         for (int i = 0; i < 4; i++) m_live[i] = nlive[i];
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (m_rdv) chk(m_tag, rd_data, m_rd);
         chk("R9 irq level", {63'h0, irq}, {63'h0, |(m_stat & m_mask)});
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] v);
      req_valid = 1; req_write = 1; req_addr = a; req_wdata = {v, 32'h0};
      @(negedge clk);
      req_valid = 0; req_write = 0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [63:0] v);
      req_valid = 1; req_write = 0; req_addr = a;
      @(negedge clk);
      v = rd_data;
      req_valid = 0;
   endtask

   task automatic ev_for(input logic [7:0] e, input int n);
      event_in = e;
      repeat (n) @(negedge clk);
      event_in = 0;
   endtask

   task automatic finish_run;
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [63:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      rd(4'd8, v); chk("R1 control after reset", v, 64'h0);
      rd(4'd2, v); chk("R1 counter after reset", v, 64'h0);
      rd(4'd9, v); chk("R1 status after reset", v, 64'h0);
      chk("R1 irq after reset", {63'h0, irq}, 64'h0);
      // R4 latch while stopped
      event_in = 8'h01;
      wr(4'd0, 32'h10);
      rd(4'd0, v); chk("R4 pending latch read", v, {32'h10, 32'h0});
      event_in = 0;
      // R5 commit on enable, R2 full width counting
      wr(4'd8, 32'h8000_0000);
      rd(4'd0, v); chk("R5 committed value", v, {32'h10, 32'h0});
      ev_for(8'h11, 5);
      rd(4'd0, v); chk("R2 full count", v, {32'h15, 32'h0});
      rd(4'd4, v); chk("R2 alias slot", v, {32'h15, 32'h0});
      // R7 freeze
      wr(4'd8, 32'h0);
      ev_for(8'hFF, 5);
      rd(4'd0, v); chk("R7 frozen count", v, {32'h15, 32'h0});
      // R6 half merge, R3 split counting
      wr(4'd8, 32'h1);
      wr(4'd0, 32'hABCD);
      rd(4'd4, v); chk("R6 lower kept", v, {32'h15, 32'h0});
      rd(4'd0, v); chk("R4 upper pending", v, {32'hABCD, 32'h0});
      wr(4'd4, 32'h1234);
      wr(4'd8, 32'h8000_0001);
      ev_for(8'h01, 3);
      rd(4'd0, v); chk("R3 upper half", v, {32'hABD0, 32'h0});
      rd(4'd4, v); chk("R6 lower merged", v, {32'h1234, 32'h0});
      // R8 wrap, R9 mask, R5 recommit while enabled
      wr(4'd9, 32'h10);
      wr(4'd4, 32'hFFFE);
      rd(4'd4, v); chk("R4 pending while enabled", v, {32'hFFFE, 32'h0});
      wr(4'd8, 32'h8000_0001);
      ev_for(8'h10, 2);
      chk("R9 irq on masked wrap", {63'h0, irq}, 64'h1);
      rd(4'd4, v); chk("R8 lower wrapped", v, 64'h0);
      rd(4'd0, v); chk("R3 no carry", v, {32'hABD0, 32'h0});
      rd(4'd9, v); chk("R8 status bit", v, {32'h10, 32'h0});
      chk("R8 irq after clear", {63'h0, irq}, 64'h0);
      rd(4'd9, v); chk("R8 status cleared", v, 64'h0);
      // R9 zero mask
      wr(4'd9, 32'h0);
      wr(4'd4, 32'hFFFF);
      wr(4'd8, 32'h8000_0001);
      ev_for(8'h10, 1);
      chk("R9 zero mask", {63'h0, irq}, 64'h0);
      rd(4'd9, v); chk("R9 status still set", v, {32'h10, 32'h0});
      // R10 lower half ignored
      req_valid = 1; req_write = 1; req_addr = 4'd8; req_wdata = {32'h8000_0001, 32'hFFFF_FFFF};
      @(negedge clk);
      req_valid = 0; req_write = 0;
      rd(4'd8, v); chk("R10 lower word", v, {32'h8000_0001, 32'h0});
      rd(4'd12, v); chk("R10 empty slot", v, 64'h0);
      // random traffic against the model
      for (int it = 0; it < 4000; it++) begin
         int r;
         logic [31:0] val;
         r = $urandom_range(0, 9);
         event_in = 8'($urandom);
         req_valid = 0; req_write = 0;
         case (r)
            0, 1: begin
               case ($urandom_range(0, 2))
                  0: val = $urandom;
                  1: val = 32'hFFFF_FFF0 | 32'($urandom_range(0, 15));
                  default: val = 32'h0000_FFF0 | 32'($urandom_range(0, 15));
               endcase
               req_valid = 1; req_write = 1; req_addr = 4'($urandom_range(0, 7));
               req_wdata = {val, 32'($urandom)};
            end
            2: begin
               val = {($urandom_range(0, 3) != 0), 27'h0, 4'($urandom)};
               req_valid = 1; req_write = 1; req_addr = 4'd8; req_wdata = {val, 32'h0};
            end
            3: begin
               req_valid = 1; req_write = 1; req_addr = 4'd9; req_wdata = {24'h0, 8'($urandom), 32'h0};
            end
            4, 5, 6: begin
               req_valid = 1; req_write = 0; req_addr = 4'($urandom_range(0, 10));
            end
            default: ;
         endcase
         @(negedge clk);
      end
      req_valid = 0; event_in = 0;
      @(negedge clk);
      finish_run();
   end
endmodule